// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, split into three banks of 32, and folds them into one interrupt request towards a processor. Software reaches it over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Each line has a mask bit. Software changes the mask only through write-one-to-set and write-one-to-clear registers, so it never needs a read-modify-write sequence. A per-bank pending register shows which lines are both asserted and unmasked.

After the processor takes an interrupt, it writes the control register to signal that it is done. The output then stays low for one cycle and comes back only if an unmasked line is still high. A configuration register holds an autoidle enable bit and a soft-reset request. While the soft reset runs, a status bit reads 0, and software polls that bit to learn when the reset has finished.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After hardware reset, every mask bit is 1, `irq_out` is 0, the configuration register reads 0 and status bit 0 reads 1.
- R2: Writing word offset 0x8C + 0x20*b (b = 0..2) sets the mask bit of every line of bank b whose data bit is 1. Bits written as 0 leave their lines unchanged. Line n lies in bank n/32 at bit n%32.
- R3: Writing word offset 0x88 + 0x20*b clears the mask bit of every line of bank b whose data bit is 1. Bits written as 0 leave their lines unchanged.
- R4: A read of either the mask-set offset or the mask-clear offset of bank b returns the current 32 mask bits of that bank.
- R5: A read of offset 0x98 + 0x20*b returns the input levels of bank b ANDed with the inverted mask bits.
- R6: `irq_out` is 1 exactly when some pending bit is 1 and no acknowledge was accepted at the previous clock edge.
- R7: A write to offset 0x48 with data bit 0 set holds `irq_out` low for the one following cycle. After that cycle, `irq_out` rises again if a pending bit is still set. A write to 0x48 with data bit 0 clear has no effect.
- R8: Offset 0x00 reads 0x10: major revision 1 in bits [7:4], minor revision 0 in bits [3:0], and all other bits 0. Writes to this offset are ignored.
- R9: Configuration offset 0x10: bit 0 is an autoidle enable that can be written and read back. Writing bit 1 as 1 starts a soft reset. The soft reset sets all mask bits to 1 and clears autoidle. Bit 1 then reads 1 for 4 cycles and clears itself.
- R10: Status offset 0x14 bit 0 reads 0 while a soft reset is running and 1 otherwise. Writes to the mask and configuration registers during a soft reset are ignored.
- R11: Reads of unmapped or unaligned offsets return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 96 | Level-sensitive interrupt inputs, line n at bit n |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench checks the acknowledge window edge by edge. It looks for a block that never releases the output and for one that masks the output for longer than one cycle. It writes to the set and clear registers with sparse random patterns, so a block that treats the written zeros as data, or that maps banks to the wrong stride, shows wrong masks on readback. It counts the soft-reset busy window cycle by cycle and tries a mask write in the middle of that window, which exposes an off-by-one counter or a write that leaks through. It also probes unaligned and unmapped offsets, which catch a decoder that ignores the low address bits.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NUM_BANKS   = 3,
  parameter int SRST_CYCLES = 4,
  parameter logic [7:0] REVISION = 8'h10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_BANKS*32-1:0]   irq_lines,
  output logic                      irq_out
);
  localparam int NLINES = NUM_BANKS * 32;
  localparam int CW     = $clog2(SRST_CYCLES + 1);
  localparam logic [7:0] OFF_REV  = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h14;
  localparam logic [7:0] OFF_CTRL = 8'h48;
  localparam logic [7:0] OFF_CLR  = 8'h88;
  localparam logic [7:0] OFF_SET  = 8'h8C;
  localparam logic [7:0] OFF_PEND = 8'h98;
  localparam logic [7:0] STRIDE   = 8'h20;

  logic [NLINES-1:0] mask_q;
  logic [NLINES-1:0] pend;
  logic [CW-1:0]     srst_cnt;
  logic              autoidle_q;
  logic              ack_q;
  logic              busy;
  logic              wr_cfg, wr_ack, start_srst;

  assign busy       = (srst_cnt != '0);
  assign pend       = irq_lines & ~mask_q;
  assign irq_out    = (|pend) && !ack_q;
  assign wr_cfg     = bus_we && (bus_addr == OFF_CFG) && !busy;
  assign wr_ack     = bus_we && (bus_addr == OFF_CTRL) && bus_wdata[0];
  assign start_srst = wr_cfg && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '1;
      autoidle_q <= 1'b0;
      srst_cnt   <= '0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= wr_ack;
      if (busy) srst_cnt <= srst_cnt - 1'b1;
      if (start_srst) begin
        mask_q     <= '1;
        autoidle_q <= 1'b0;
        srst_cnt   <= CW'(SRST_CYCLES);
      end else begin
        if (wr_cfg) autoidle_q <= bus_wdata[0];
        if (bus_we && !busy) begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == OFF_SET + 8'(b) * STRIDE)
              mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] | bus_wdata;
            if (bus_addr == OFF_CLR + 8'(b) * STRIDE)
              mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] & ~bus_wdata;
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_REV:  bus_rdata = {24'h0, REVISION};
      OFF_CFG:  bus_rdata = {30'h0, busy, autoidle_q};
      OFF_STAT: bus_rdata = {31'h0, !busy};
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bus_addr == OFF_SET + 8'(b) * STRIDE || bus_addr == OFF_CLR + 8'(b) * STRIDE)
            bus_rdata = mask_q[b*32 +: 32];
          if (bus_addr == OFF_PEND + 8'(b) * STRIDE)
            bus_rdata = pend[b*32 +: 32];
        end
      end
    endcase
  end

  // R7: an accepted acknowledge keeps the request low in the next cycle
  a_r7_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !irq_out);
  // R6: the request never rises without an unmasked active line
  a_r6_out_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(irq_lines & ~mask_q));
  // R9: a soft reset leaves every line masked and autoidle off
  a_r9_srst_restores: assert property (@(posedge clk) disable iff (!rst_n)
    start_srst |=> (&mask_q && !autoidle_q && busy));
  // R10: masks are frozen while the soft reset runs
  a_r10_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_q));
  // R9: the busy counter never exceeds its load value
  a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    srst_cnt <= CW'(SRST_CYCLES));
endmodule

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [95:0] irq_lines = 0;
  logic        irq_out;
  int errors = 0, checks = 0;
  logic [95:0] mask_m;
  bit done = 0;

  banked_irq_ctrl i_banked_irq_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0; bus_addr = 8'hF0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic exp_irq(logic [95:0] l, logic [95:0] m);
    return |(l & ~m);
  endfunction

  task automatic check_all(string tag);
    logic [31:0] v;
    for (int b = 0; b < 3; b++) begin
      rd(8'h8C + 8'(b*32), v); check({tag, " R4 set-read"}, v, mask_m[b*32 +: 32]);
      rd(8'h88 + 8'(b*32), v); check({tag, " R4 clr-read"}, v, mask_m[b*32 +: 32]);
      rd(8'h98 + 8'(b*32), v); check({tag, " R5 pending"}, v, irq_lines[b*32 +: 32] & ~mask_m[b*32 +: 32]);
    end
    check({tag, " R6 irq_out"}, 32'(irq_out), 32'(exp_irq(irq_lines, mask_m)));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    mask_m = '1;
    #(CLK_PERIOD*2); @(negedge clk); rst_n = 1;
    // R1 reset state
    irq_lines = '1;
    @(negedge clk);
    check("R1 irq_out", 32'(irq_out), 0);
    rd(8'h10, v); check("R1 cfg", v, 0);
    rd(8'h14, v); check("R1 status", v, 1);
    check_all("R1");
    // R8 revision, write ignored
    rd(8'h00, v); check("R8 rev", v, 32'h10);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R8 rev after write", v, 32'h10);
    // R3 / R2 directed: line 40 (bank1 bit 8)
    irq_lines = 96'h0;
    irq_lines[40] = 1;
    wr(8'hA8, 32'h0000_0100); mask_m[40] = 0;
    check_all("R3 line40");
    wr(8'hAC, 32'h0000_0000);
    check_all("R2 zero write");
    wr(8'hAC, 32'h0000_0100); mask_m[40] = 1;
    check_all("R2 line40");
    // random mask and line traffic
    for (int i = 0; i < 200; i++) begin
      int b = $urandom_range(0, 2);
      logic [31:0] d = $urandom() & $urandom();
      irq_lines = {$urandom(), $urandom(), $urandom()} & {$urandom(), $urandom(), $urandom()};
      if ($urandom_range(0, 1) == 1) begin
        wr(8'h8C + 8'(b*32), d); mask_m[b*32 +: 32] |= d;
      end else begin
        wr(8'h88 + 8'(b*32), d); mask_m[b*32 +: 32] &= ~d;
      end
      check_all(i[0] ? "R2 random" : "R3 random");
    end
    // R7 acknowledge window
    wr(8'h88, 32'hFFFF_FFFF); mask_m[31:0] = '0;
    irq_lines = 96'h1;
    @(negedge clk); bus_addr = 8'h48; bus_wdata = 32'h0; bus_we = 1;
    @(negedge clk); bus_we = 0;
    check("R7 ack with bit0 clear", 32'(irq_out), 1);
    @(negedge clk); bus_addr = 8'h48; bus_wdata = 32'h1; bus_we = 1;
    @(negedge clk); bus_we = 0;
    check("R7 blocked cycle", 32'(irq_out), 0);
    @(negedge clk);
    check("R7 reassert", 32'(irq_out), 1);
    @(negedge clk); bus_addr = 8'h48; bus_wdata = 32'h1; bus_we = 1;
    @(negedge clk); bus_we = 0; irq_lines = '0;
    @(negedge clk);
    check("R7 no spurious", 32'(irq_out), 0);
    // R9 autoidle
    wr(8'h10, 32'h1);
    rd(8'h10, v); check("R9 autoidle", v, 1);
    // R9 / R10 soft reset
    irq_lines = '1;
    @(negedge clk); bus_addr = 8'h10; bus_wdata = 32'h2; bus_we = 1;
    @(negedge clk); bus_we = 0;
    mask_m = '1;
    rd(8'h10, v); check("R9 busy bit", v, 32'h2);
    rd(8'h14, v); check("R10 status busy", v, 0);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, v); check("R10 write ignored", v, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(8'h14, v); check("R10 status cycle4", v, 0);
    @(negedge clk);
    rd(8'h14, v); check("R10 status done", v, 1);
    rd(8'h10, v); check("R9 cfg cleared", v, 0);
    check_all("R9 after srst");
    // R11 unmapped / unaligned
    for (int a = 0; a < 256; a += 4) begin
      logic [7:0] aa = 8'(a);
      if (!(aa inside {8'h00, 8'h10, 8'h14, 8'h88, 8'h8C, 8'h98, 8'hA8, 8'hAC, 8'hB8, 8'hC8, 8'hCC, 8'hD8})) begin
        rd(aa, v); check("R11 unmapped read", v, 0);
      end
    end
    rd(8'h89, v); check("R11 unaligned read", v, 0);
    wr(8'h89, 32'hFFFF_FFFF);
    wr(8'h84, 32'hFFFF_FFFF);
    check_all("R11 unmapped write");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule